// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

This block is a synthesizable behavioural model of a synchronous SRAM core that never wastes a data-bus cycle when the bus changes direction. Address, control and byte strobes are captured at a rising clock edge. The data transfer for that command, read or write, happens exactly two edges later. Because every command has the same latency, reads and writes can be mixed freely, one per clock, and the data bus stays fully used.

The core has an active-low clock enable that freezes the whole pipeline. Three chip-select inputs gate the start of new operations. Per-lane write strobes allow byte writes. An asynchronous output enable can switch off the read-data drivers at any moment. The bidirectional data bus is split into a write-data input, a read-data output and a drive-enable output.

A load/advance input picks between two kinds of command. A load command is decoded from the select and read/write pins. An advance command repeats the previous load's operation at whatever address an external burst sequencer presents.

Top module: `zbt_sram_core`

## Requirements
- R1: A read command accepted at an enabled edge k produces the addressed word on `rdata`, with `rdata_oe` high, right after the second enabled edge following k.
- R2: A write command accepted at enabled edge k stores `wdata` as sampled at the second enabled edge after k. Only lanes whose strobe bit in `byte_en_n` was 0 at edge k are updated. Lane i is `wdata[i*LANE_W +: LANE_W]`.
- R3: Commands may alternate between read and write on every cycle with no idle cycle. A read accepted two enabled edges after a write to the same address returns the newly written data.
- R4: The device is selected when `cs_hi`=1, `cs_lo_a_n`=0 and `cs_lo_b_n`=0. A load command (`adv_load`=0) while not selected starts no operation, but operations already in flight still complete.
- R5: `rdata_oe` is low after the second enabled edge following a write command or a deselected command.
- R6: While `clk_en_n`=1, all synchronous inputs are ignored and all state holds. `rdata`, `rdata_oe` and pending operations stay as they were, and pending operations resume when enable returns.
- R7: `oe_n`=1 forces `rdata_oe` low at once, independent of the clock. Returning `oe_n` to 0 restores the driven state.
- R8: An advance command (`adv_load`=1) repeats the operation type and select state of the most recent load command, at the current `addr`. The `wr`, `cs_hi`, `cs_lo_a_n` and `cs_lo_b_n` inputs are ignored for that command.
- R9: After reset, no operation is pending and `rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of control state |
| clk_en_n | input | 1 | Active-low clock enable; high stalls everything |
| adv_load | input | 1 | 0 = load new command, 1 = advance (repeat last operation) |
| cs_hi | input | 1 | Active-high chip select |
| cs_lo_a_n | input | 1 | First active-low chip select |
| cs_lo_b_n | input | 1 | Second active-low chip select |
| wr | input | 1 | 1 = write, 0 = read, for load commands |
| byte_en_n | input | LANES | Active-low per-lane write strobes |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Write data, sampled two edges after its command |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | LANES*LANE_W | Read data from the output register |
| rdata_oe | output | 1 | Read-data bus drive enable |

## Verification
The bench builds the core with its defaults: 64 words of four 8-bit lanes. With so few words, random addresses collide often, so a read two edges after a write to the same word happens many times. Partial strobes on one word then leave mixed old and new lanes that the reference memory must match. The narrow four-lane strobe field lets random patterns cover every mask, including all lanes off. The short depth also lets the bench fill the whole array with known data in 64 cycles before any random read.

// File: rtl/zbt_sram_core.sv
module zbt_sram_core #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clk_en_n,
  input  logic                      adv_load,
  input  logic                      cs_hi,
  input  logic                      cs_lo_a_n,
  input  logic                      cs_lo_b_n,
  input  logic                      wr,
  input  logic [LANES-1:0]          byte_en_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      oe_n,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rdata_oe
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] dout;
  logic              run, sel;
  logic              b_act, b_wr, v1, w1, v2, w2, drv;
  logic [ADDR_W-1:0] a1, a2;
  logic [LANES-1:0]  m1, m2;

  assign run = !clk_en_n;
  assign sel = cs_hi && !cs_lo_a_n && !cs_lo_b_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_act <= 1'b0;
      b_wr  <= 1'b0;
      v1    <= 1'b0;
      w1    <= 1'b0;
      v2    <= 1'b0;
      w2    <= 1'b0;
      drv   <= 1'b0;
    end else if (run) begin
      if (adv_load) begin
        v1 <= b_act;
        w1 <= b_wr;
      end else begin
        v1    <= sel;
        w1    <= wr;
        b_act <= sel;
        b_wr  <= wr;
      end
      v2  <= v1;
      w2  <= w1;
      drv <= v2 && !w2;
    end
  end

  always_ff @(posedge clk) begin
    if (run) begin
      a1 <= addr;
      m1 <= byte_en_n;
      a2 <= a1;
      m2 <= m1;
      if (v2 && !w2) dout <= mem[a2];
      if (v2 && w2)
        for (int l = 0; l < LANES; l++)
          if (!m2[l]) mem[a2][l*LANE_W +: LANE_W] <= wdata[l*LANE_W +: LANE_W];
    end
  end

  assign rdata    = dout;
  assign rdata_oe = drv && !oe_n;
endmodule

// File: rtl/zbt_sram_core_chk.sv
module zbt_sram_core_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clk_en_n,
  input logic              adv_load,
  input logic              cs_hi,
  input logic              cs_lo_a_n,
  input logic              cs_lo_b_n,
  input logic              oe_n,
  input logic              rdata_oe,
  input logic [DATA_W-1:0] rdata,
  input logic              v1,
  input logic              v2,
  input logic              w2,
  input logic [ADDR_W-1:0] a1
);
  p_deselect_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !adv_load && !(cs_hi && !cs_lo_a_n && !cs_lo_b_n)) |=> !v1);

  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(rdata) && $stable(v1) && $stable(a1)));

  p_write_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && v2 && w2) |=> !rdata_oe);

  p_read_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && v2 && !w2) |=> (rdata_oe || oe_n));
endmodule

bind zbt_sram_core zbt_sram_core_chk #(.ADDR_W(ADDR_W), .DATA_W(LANES*LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_load(adv_load),
  .cs_hi(cs_hi), .cs_lo_a_n(cs_lo_a_n), .cs_lo_b_n(cs_lo_b_n), .oe_n(oe_n),
  .rdata_oe(rdata_oe), .rdata(rdata), .v1(v1), .v2(v2), .w2(w2), .a1(a1)
);

// File: tb/zbt_sram_core_test.sv
`timescale 1ns/1ps
module zbt_sram_core_test;
  localparam int AW = 6, LN = 4, LW = 8, DW = LN * LW, DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, clk_en_n = 0, adv_load = 0;
  logic cs_hi = 0, cs_lo_a_n = 1, cs_lo_b_n = 1, wr = 0, oe_n = 0;
  logic [LN-1:0] byte_en_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic rdata_oe;

  zbt_sram_core #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv_load(adv_load),
    .cs_hi(cs_hi), .cs_lo_a_n(cs_lo_a_n), .cs_lo_b_n(cs_lo_b_n), .wr(wr),
    .byte_en_n(byte_en_n), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rdata_oe(rdata_oe));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [DW-1:0] m_mem [DEPTH];
  logic [DW-1:0] e_data;
  bit e_drv, b_act, b_wr, p1v, p1w, p2v, p2w;
  logic [AW-1:0] p1a, p2a;
  logic [LN-1:0] p1m, p2m;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw, input logic [LN-1:0] m);
    logic [DW-1:0] r = old;
    for (int l = 0; l < LN; l++) if (!m[l]) r[l*LW +: LW] = nw[l*LW +: LW];
    return r;
  endfunction

  task automatic model_edge();
    if (clk_en_n) return;
    if (p2v && p2w) m_mem[p2a] = merge(m_mem[p2a], wdata, p2m);
    if (p2v && !p2w) e_data = m_mem[p2a];
    e_drv = p2v && !p2w;
    p2v = p1v; p2w = p1w; p2a = p1a; p2m = p1m;
    if (adv_load) begin
      p1v = b_act; p1w = b_wr;
    end else begin
      p1v = cs_hi && !cs_lo_a_n && !cs_lo_b_n; p1w = wr;
      b_act = p1v; b_wr = wr;
    end
    p1a = addr; p1m = byte_en_n;
  endtask

  task automatic look(input string tag);
    chk(rdata_oe == (e_drv && !oe_n), tag, {31'd0, rdata_oe}, {31'd0, e_drv && !oe_n});
    if (e_drv) chk(rdata === e_data, tag, rdata, e_data);
  endtask

  task automatic step(input string tag, input bit st, input bit adv, input bit ch, input bit ca,
                      input bit cb, input bit w, input logic [AW-1:0] a, input logic [LN-1:0] m);
    clk_en_n = st; adv_load = adv; cs_hi = ch; cs_lo_a_n = ca; cs_lo_b_n = cb;
    wr = w; addr = a; byte_en_n = m; wdata = {$urandom, $urandom} [DW-1:0];
    @(posedge clk);
    model_edge();
    @(negedge clk);
    look(tag);
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a);
    step(tag, 0, 0, 1, 0, 0, 0, a, '1);
  endtask
  task automatic wt(input string tag, input logic [AW-1:0] a, input logic [LN-1:0] m);
    step(tag, 0, 0, 1, 0, 0, 1, a, m);
  endtask
  task automatic nop(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, '0, '1);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(rdata_oe == 0, "R9", {31'd0, rdata_oe}, 0);
    for (int i = 0; i < DEPTH; i++) wt("R2", i[AW-1:0], '0);
    nop("R5"); nop("R5");
    rd("R1", 6'd5); nop("R1"); nop("R1");
    chk(rdata_oe == 1, "R1", {31'd0, rdata_oe}, 1);
    wt("R3", 6'd20, '0); wt("R3", 6'd21, '0); rd("R3", 6'd20); rd("R3", 6'd21);
    wt("R3", 6'd20, '0); rd("R3", 6'd21); rd("R3", 6'd20); wt("R3", 6'd22, '0);
    rd("R3", 6'd22); nop("R3"); nop("R3");
    wt("R2", 6'd30, 4'b0101); wt("R2", 6'd31, 4'b1111); rd("R2", 6'd30); rd("R2", 6'd31);
    nop("R2"); nop("R2");
    rd("R4", 6'd7); step("R4", 0, 0, 0, 0, 0, 0, 6'd8, '1);
    step("R4", 0, 0, 1, 1, 0, 0, 6'd9, '1); step("R4", 0, 0, 1, 0, 1, 0, 6'd9, '1);
    nop("R4"); nop("R4");
    chk(rdata_oe == 0, "R4", {31'd0, rdata_oe}, 0);
    rd("R8", 6'd40); step("R8", 0, 1, 0, 1, 1, 1, 6'd41, '0);
    step("R8", 0, 1, 0, 1, 1, 1, 6'd42, '0); wt("R8", 6'd43, '0);
    step("R8", 0, 1, 0, 1, 1, 0, 6'd44, '0); nop("R8");
    step("R8", 0, 1, 1, 0, 0, 1, 6'd45, '0); nop("R8"); nop("R8");
    rd("R6", 6'd50); rd("R6", 6'd51);
    for (int i = 0; i < 3; i++) step("R6", 1, 0, 1, 0, 0, 1, 6'd52, '0);
    nop("R6"); nop("R6"); nop("R6");
    rd("R5", 6'd3); wt("R5", 6'd3, 4'b0011); nop("R5"); nop("R5");
    rd("R7", 6'd9); nop("R7"); nop("R7");
    #1 oe_n = 1; #1;
    chk(rdata_oe == 0, "R7", {31'd0, rdata_oe}, 0);
    oe_n = 0; #1;
    chk(rdata_oe == 1, "R7", {31'd0, rdata_oe}, 1);
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      oe_n = ($urandom_range(0, 9) == 0);
      step("R3", r < 8, r >= 8 && r < 25, r % 11 != 0, r % 13 == 0, 0,
           $urandom_range(0, 1), $urandom_range(0, DEPTH - 1), $urandom_range(0, 15));
    end
    oe_n = 0; nop("R3"); nop("R3");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule